// File: doc/BRIEF.md
# BCD Calendar Clock with Coherent Snapshot

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours, day of month, month, two-digit year and a day-of-week counter. A single-cycle pulse on `tick` marks each elapsed second. A byte-wide register port lets a controller read every field, set the time and drive a small control register. The status register carries a sticky flag that shows a second was counted since it was last read.

Setting the time is a three-step sequence. The controller clears the run bit so the counters hold. It then writes the fields, and writes the run bit back to 1. The port can be slow, for example a serial bridge that moves one byte per transaction. To read the time safely over such a port, the controller writes a 0-to-1 on the snapshot bit. That copies all seven live fields into a shadow bank on a single edge. It then sets the read-select bit, so that reads of the time addresses come from the shadows, and every byte it reads belongs to the same instant.

Top module: `calclk_top`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x01, the control register reads 0x01 (running) and the status register reads 0x00.
- R2: The address map is seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06, control 0x10 and status 0x11. Reads of any other address return 0x00, and reads return data combinationally in the cycle the address is presented.
- R3: Control bit 0 is the run bit. A `tick` advances the time only while this bit is 1. A tick that arrives while it is 0 changes no field and does not set the status flag.
- R4: A write to a time address takes effect only while the run bit is 0, and a write while running is ignored. Stored values are masked to the width of each field: seconds and minutes 0x7F, hours and day 0x3F, month 0x1F, year 0xFF, weekday 0x07.
- R5: Seconds wrap from 59 to 00 and advance the minutes. Minutes wrap from 59 to 00 and advance the hours. Hours wrap from 23 to 00 and advance both the day and the weekday. The weekday runs 1 to 7 and then wraps to 1.
- R6: The day wraps back to 01 after the last day of the month: 31 days, 30 days for months 04, 06, 09 and 11, and for month 02 either 29 days when the binary year value is a multiple of 4 or 28 days otherwise. The month wraps from 12 to 01 and advances the year, which wraps from 99 to 00.
- R7: A control write that takes bit 6 from 0 to 1 copies all seven live fields into the shadow bank at that same clock edge. The copy holds the values present before any tick counted on that edge. A write that leaves bit 6 at 1, or that clears it, takes no snapshot.
- R8: While control bit 7 is 1, reads of addresses 0x00 to 0x06 return the shadow bank. While it is 0 they return the live fields.
- R9: Status bit 0 is set by every counted tick and cleared by a read of address 0x11 (`rd_en` high). If a tick is counted in the same cycle as that read, the flag ends up set. The read in that cycle returns the previous value.
- R10: The control register reads back bit 7, bit 6 and bit 0 as last written, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only on status) |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
A wrong carry or terminal value in the counter chain shows up at the ports on the tick that crosses that boundary. The first read after that tick returns a field that is off by one or not wrapped. A month-length error appears only on the last day of the affected month, so the bench sweeps every month of every year. A snapshot taken on the wrong condition is visible as a shadow value that differs from the value captured before the following ticks. A status flag that is not sticky reads as a wrong bit on the very next status read.

// File: rtl/calclk_pkg.sv
// Package calclk_pkg
// Shared widths, register addresses, the field bank type and BCD helpers for
// the calendar clock. Field index equals its register address.
package calclk_pkg;
    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int NFIELD = 7;

    localparam logic [AW-1:0] A_SEC  = 8'h00;
    localparam logic [AW-1:0] A_MIN  = 8'h01;
    localparam logic [AW-1:0] A_HR   = 8'h02;
    localparam logic [AW-1:0] A_DAY  = 8'h03;
    localparam logic [AW-1:0] A_MON  = 8'h04;
    localparam logic [AW-1:0] A_YR   = 8'h05;
    localparam logic [AW-1:0] A_WDAY = 8'h06;
    localparam logic [AW-1:0] A_CTRL = 8'h10;
    localparam logic [AW-1:0] A_STAT = 8'h11;

    typedef logic [DW-1:0] byte_t;
    typedef logic [NFIELD-1:0][DW-1:0] tm_t;

    // Storage mask per field index.
    function automatic byte_t f_mask(input int idx);
        case (idx)
            0, 1:    return 8'h7F;
            2, 3:    return 8'h3F;
            4:       return 8'h1F;
            6:       return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction

    // Value a field takes at reset and after it wraps.
    function automatic byte_t f_floor(input int idx);
        case (idx)
            3, 4, 6: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Next BCD value of a two-digit counter.
    function automatic byte_t bcd_inc(input byte_t v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last day (BCD) of a BCD month in a BCD two-digit year.
    function automatic byte_t month_len(input byte_t mon, input byte_t yr);
        int ybin;
        ybin = int'(yr[7:4]) * 10 + int'(yr[3:0]);
        case (mon)
            8'h02:                      return (ybin % 4 == 0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/calclk_field.sv
// Module calclk_field
// One BCD time field. It loads a masked value, or steps and wraps to its floor
// when a step arrives while it sits at its terminal value.
// Assumes load and step are never active together (load only while frozen).
module calclk_field
    import calclk_pkg::*;
#(
    parameter byte_t MASK  = 8'hFF,
    parameter byte_t FLOOR = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  load,
    input  byte_t wrap_at,
    input  byte_t load_val,
    output byte_t value,
    output logic  carry
);
    // Carry out when stepping from the terminal value.
    always_comb carry = step && (value == wrap_at);

    // Field register: load, wrap or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= FLOOR;
        else if (load)   value <= load_val & MASK;
        else if (carry)  value <= FLOOR;
        else if (step)   value <= bcd_inc(value);
    end

    // R5/R6: stepping past the terminal value lands on the floor.
    a_r5_wrap_to_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !load) |=> (value == FLOOR));

    // R3: no step and no load leaves the field unchanged.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(value));
endmodule

// File: rtl/calclk_counter.sv
// Module calclk_counter
// Bank of seven BCD fields linked by a carry chain: sec -> min -> hour ->
// (day, weekday); day -> month -> year. Day terminal follows month and leap year.
// Assumes tick_ok is a single-cycle pulse and load_en is one-hot or zero.
module calclk_counter
    import calclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ok,
    input  logic [NFIELD-1:0] load_en,
    input  byte_t             load_val,
    output tm_t               live
);
    logic [NFIELD-1:0] step;
    logic [NFIELD-1:0] carry;
    tm_t               wrap;

    // Carry routing between fields.
    always_comb begin
        step[0] = tick_ok;
        step[1] = carry[0];
        step[2] = carry[1];
        step[3] = carry[2];
        step[4] = carry[3];
        step[5] = carry[4];
        step[6] = carry[2];
    end

    // Terminal value of each field.
    always_comb begin
        wrap[0] = 8'h59;
        wrap[1] = 8'h59;
        wrap[2] = 8'h23;
        wrap[3] = month_len(live[4], live[5]);
        wrap[4] = 8'h12;
        wrap[5] = 8'h99;
        wrap[6] = 8'h07;
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        calclk_field #(
            .MASK (f_mask(g)),
            .FLOOR(f_floor(g))
        ) u_fld (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step[g]),
            .load    (load_en[g]),
            .wrap_at (wrap[g]),
            .load_val(load_val),
            .value   (live[g]),
            .carry   (carry[g])
        );
    end

    // R6: year 99 rolls to 00.
    a_r6_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        carry[5] |=> (live[5] == 8'h00));

    // R5: weekday 7 rolls to 1.
    a_r5_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        carry[6] |=> (live[6] == 8'h01));
endmodule

// File: rtl/calclk_ctrl.sv
// Module calclk_ctrl
// Control bits (run, snapshot, read-select), snapshot edge detect and the
// sticky tick status flag. Assumes the write strobe is already address-decoded.
module calclk_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic new_run,
    input  logic new_snap,
    input  logic new_rsel,
    input  logic rd_stat,
    input  logic tick,
    output logic run,
    output logic snap_bit,
    output logic rsel,
    output logic snap_pulse,
    output logic tick_ok,
    output logic stat_flag
);
    // Snapshot fires only on a written 0-to-1 of the snapshot bit.
    always_comb snap_pulse = wr_ctrl && new_snap && !snap_bit;

    // Ticks count only while running.
    always_comb tick_ok = tick && run;

    // Control register bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b1;
            snap_bit <= 1'b0;
            rsel     <= 1'b0;
        end else if (wr_ctrl) begin
            run      <= new_run;
            snap_bit <= new_snap;
            rsel     <= new_rsel;
        end
    end

    // Sticky status flag; a counted tick wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_flag <= 1'b0;
        else if (tick_ok) stat_flag <= 1'b1;
        else if (rd_stat) stat_flag <= 1'b0;
    end

    // R7: a snapshot never repeats on the following cycle.
    a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pulse |=> !snap_pulse);

    // R9: a counted tick leaves the flag set.
    a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        tick_ok |=> stat_flag);

    // R9: a status read without a tick clears the flag.
    a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !tick_ok) |=> !stat_flag);
endmodule

// File: rtl/calclk_shadow.sv
// Module calclk_shadow
// Shadow bank: takes a copy of the whole live field bank on a capture pulse
// and holds it otherwise.
module calclk_shadow
    import calclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  tm_t  d,
    output tm_t  q
);
    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (cap) q <= d;
    end

    // R7: without a capture the shadow bank does not move.
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(q));
endmodule

// File: rtl/calclk_top.sv
// Module calclk_top
// Calendar clock register block: address decode, write gating while frozen,
// read mux between live, shadow, control and status.
// Assumes tick is a one-cycle pulse per second, synchronous to clk.
module calclk_top
    import calclk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic              run, snap_bit, rsel, snap_pulse, tick_ok, stat_flag;
    logic              wr_ctrl, rd_stat;
    logic [NFIELD-1:0] load_en;
    tm_t               live, shadow;

    // Strobe decode for control write and status read.
    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        rd_stat = rd_en && (addr == A_STAT);
    end

    // Field loads are allowed only while frozen.
    always_comb begin
        for (int i = 0; i < NFIELD; i++)
            load_en[i] = wr_en && !run && (addr == AW'(i));
    end

    calclk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .new_run   (wdata[0]),
        .new_snap  (wdata[6]),
        .new_rsel  (wdata[7]),
        .rd_stat   (rd_stat),
        .tick      (tick),
        .run       (run),
        .snap_bit  (snap_bit),
        .rsel      (rsel),
        .snap_pulse(snap_pulse),
        .tick_ok   (tick_ok),
        .stat_flag (stat_flag)
    );

    calclk_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_ok (tick_ok),
        .load_en (load_en),
        .load_val(wdata),
        .live    (live)
    );

    calclk_shadow u_shd (
        .clk  (clk),
        .rst_n(rst_n),
        .cap  (snap_pulse),
        .d    (live),
        .q    (shadow)
    );

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NFIELD; i++)
            if (addr == AW'(i)) rdata = rsel ? shadow[i] : live[i];
        if (addr == A_CTRL) rdata = {rsel, snap_bit, 5'b0, run};
        if (addr == A_STAT) rdata = {7'b0, stat_flag};
    end

    // R3: while frozen, seconds move only by a direct write.
    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && addr == A_SEC)) |=> $stable(live[0]));

    // R4: a minutes write while running, with no tick, changes nothing.
    a_r4_running_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && wr_en && addr == A_MIN) |=> $stable(live[1]));

    // R7: the shadow bank holds the live bank as it stood at the snapshot edge.
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pulse |=> (shadow == $past(live)));
endmodule

// File: tb/sim_calclk_top.sv
module sim_calclk_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    calclk_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic settime(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                           input logic [7:0] w);
        wr(8'h10, 8'h00);
        wr(8'h00, s); wr(8'h01, mi); wr(8'h02, h); wr(8'h03, d);
        wr(8'h04, mo); wr(8'h05, y); wr(8'h06, w);
        wr(8'h10, 8'h01);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int s, mi, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 sec", 8'h00, 8'h00);
        rdchk("R1 min", 8'h01, 8'h00);
        rdchk("R1 hour", 8'h02, 8'h00);
        rdchk("R1 day", 8'h03, 8'h01);
        rdchk("R1 month", 8'h04, 8'h01);
        rdchk("R1 year", 8'h05, 8'h00);
        rdchk("R1 wday", 8'h06, 8'h01);
        rdchk("R1 ctrl", 8'h10, 8'h01);
        rdchk("R1 status", 8'h11, 8'h00);

        // R2 unmapped addresses read zero
        rdchk("R2 addr07", 8'h07, 8'h00);
        rdchk("R2 addr08", 8'h08, 8'h00);
        rdchk("R2 addr0F", 8'h0F, 8'h00);
        rdchk("R2 addr12", 8'h12, 8'h00);
        rdchk("R2 addrFF", 8'hFF, 8'h00);

        // R9 sticky flag and clear on read
        pulse_tick();
        rdchk("R3 running tick counts", 8'h00, 8'h01);
        rdchk("R9 flag set", 8'h11, 8'h01);
        rdchk("R9 flag cleared by read", 8'h11, 8'h00);

        // R4 write while running is ignored
        wr(8'h00, 8'h42);
        rdchk("R4 running write ignored", 8'h00, 8'h01);

        // R3 frozen: tick ignored, flag not set
        wr(8'h10, 8'h00);
        wr(8'h00, 8'h42);
        rdchk("R4 frozen write taken", 8'h00, 8'h42);
        pulse_tick();
        rdchk("R3 frozen tick ignored", 8'h00, 8'h42);
        rdchk("R3 frozen tick no flag", 8'h11, 8'h00);

        // R4 masks
        for (int i = 0; i < 7; i++) wr(8'(i), 8'hFF);
        rdchk("R4 mask sec", 8'h00, 8'h7F);
        rdchk("R4 mask min", 8'h01, 8'h7F);
        rdchk("R4 mask hour", 8'h02, 8'h3F);
        rdchk("R4 mask day", 8'h03, 8'h3F);
        rdchk("R4 mask month", 8'h04, 8'h1F);
        rdchk("R4 mask year", 8'h05, 8'hFF);
        rdchk("R4 mask wday", 8'h06, 8'h07);

        // R10 control readback
        wr(8'h10, 8'h3E);
        rdchk("R10 ctrl low bits", 8'h10, 8'h00);
        wr(8'h10, 8'hFF);
        rdchk("R10 ctrl readback", 8'h10, 8'hC1);
        wr(8'h10, 8'h00);

        // R5 one hour and a bit of seconds, with hour 23 -> 00 rollover
        settime(8'h00, 8'h00, 8'h23, 8'h15, 8'h06, 8'h24, 8'h07);
        s = 0; mi = 0; h = 23;
        for (int k = 1; k <= 3605; k++) begin
            pulse_tick();
            s++;
            if (s == 60) begin s = 0; mi++; end
            if (mi == 60) begin mi = 0; h = (h + 1) % 24; end
            rdchk("R5 seconds", 8'h00, bcd(s));
            if (s == 0) begin
                rdchk("R5 minutes", 8'h01, bcd(mi));
                rdchk("R5 hours", 8'h02, bcd(h));
            end
        end
        rdchk("R5 day advanced", 8'h03, 8'h16);
        rdchk("R5 weekday 7 to 1", 8'h06, 8'h01);
        rdchk("R5 month kept", 8'h04, 8'h06);

        // R6 last-day rollover for every month of every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int w;
                w = ((y * 12 + m) % 7) + 1;
                settime(8'h59, 8'h59, 8'h23, bcd(mdays(m, y)), bcd(m), bcd(y), bcd(w));
                pulse_tick();
                rdchk("R6 sec", 8'h00, 8'h00);
                rdchk("R6 hour", 8'h02, 8'h00);
                rdchk("R6 day", 8'h03, 8'h01);
                rdchk("R6 month", 8'h04, bcd(m == 12 ? 1 : m + 1));
                rdchk("R6 year", 8'h05, bcd(m == 12 ? (y + 1) % 100 : y));
                rdchk("R5 weekday", 8'h06, bcd(w == 7 ? 1 : w + 1));
            end
        end
        // R6 day before month end does not wrap (Feb 28 in a leap year)
        settime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h01);
        pulse_tick();
        rdchk("R6 leap Feb 29", 8'h03, 8'h29);
        rdchk("R6 leap month kept", 8'h04, 8'h02);

        // R7 / R8 snapshot and read select
        settime(8'h30, 8'h20, 8'h10, 8'h05, 8'h03, 8'h11, 8'h02);
        wr(8'h10, 8'h41);
        repeat (3) pulse_tick();
        wr(8'h10, 8'hC1);
        rdchk("R8 shadow sec", 8'h00, 8'h30);
        rdchk("R8 shadow min", 8'h01, 8'h20);
        rdchk("R8 shadow month", 8'h04, 8'h03);
        rdchk("R10 ctrl C1", 8'h10, 8'hC1);
        wr(8'h10, 8'h81);
        rdchk("R7 clear bit no snapshot", 8'h00, 8'h30);
        wr(8'h10, 8'hC1);
        rdchk("R7 new edge snapshot", 8'h00, 8'h33);
        pulse_tick();
        wr(8'h10, 8'hC1);
        rdchk("R7 held bit no snapshot", 8'h00, 8'h33);
        wr(8'h10, 8'h41);
        rdchk("R8 live read", 8'h00, 8'h34);

        // R9 tick and status read in the same cycle
        wr(8'h10, 8'h01);
        rdchk("R9 pre-clear", 8'h11, 8'h01);
        @(negedge clk);
        tick = 1'b1; addr = 8'h11; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        tick = 1'b0; rd_en = 1'b0;
        chk("R9 same-cycle read old value", v, 8'h00);
        rdchk("R9 tick wins over clear", 8'h11, 8'h01);
        rdchk("R9 cleared afterwards", 8'h11, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule